// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetcher

This block accepts interrupt requests and turns an accepted request into a handler pointer. Each request carries an 8-bit vector number, a priority level and a flag that marks it as raised by hardware. The flag and the level together form a rank, and the flag is the most significant part of that rank, so any hardware request outranks any software request. A request is taken only when its rank is strictly above the rank of the task that is running now. A request that does not outrank the running task is left waiting, and the block weighs it again on every cycle.

When the block accepts a request, it pushes the rank of the running task onto a small last-in-first-out stack, and the new rank becomes current. The block then reads the 4-byte table entry at address vector×4, which lies inside the lowest 1 KB of a byte-wide memory. It reads one byte per memory handshake. When the last byte arrives, it presents the handler segment, the handler offset and the resolved 20-bit physical address together with a one-cycle valid pulse. A return pulse pops the stack and restores the rank that was preempted. The block flags a push into a full stack and a pop from an empty stack.

Top module: `irq_vector_fetcher`

## Requirements
- R1: The entry for vector v is read at byte addresses 4v, 4v+1, 4v+2 and 4v+3, in that order, and every read address stays below 0x400. The four bytes are, in order: offset low, offset high, segment low, segment high.
- R2: `mem_rd` stays high with a stable `mem_addr` until `mem_ack` is seen, and each acknowledged cycle consumes exactly one byte of `mem_data`.
- R3: A request's rank is {`req_hw`, `req_prio`}, with `req_hw` as the most significant bit, so a hardware request at level 0 outranks a software request at the highest level.
- R4: A request whose rank is equal to or below `cur_prio` gets no `req_grant` and starts no memory read.
- R5: A request that is held while it is outranked is granted without being raised again, once a return lowers `cur_prio` below its rank.
- R6: On acceptance, `req_grant` pulses for one cycle, the previous `cur_prio` is pushed onto the stack, and `cur_prio` takes the request's rank. `cur_prio` is 0 after reset.
- R7: A `ret` pulse while no fetch is in progress restores `cur_prio` from the stack in last-in-first-out order.
- R8: The stack holds 8 entries. While it is full, an outranking request raises `ovf_err` for each cycle it is held, is not granted, and leaves `cur_prio` unchanged.
- R9: A `ret` on an empty stack raises `unf_err` for one cycle and leaves `cur_prio` unchanged.
- R10: `hnd_valid` is a one-cycle pulse. With it, `hnd_seg` and `hnd_off` carry the entry, and `hnd_phys` equals (`hnd_seg`×16 + `hnd_off`) mod 2^20.
- R11: A `ret` that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request, held until granted |
| req_vector | input | 8 | Vector number |
| req_prio | input | 3 | Priority level within its class |
| req_hw | input | 1 | 1 = hardware-sourced request |
| ret | input | 1 | Handler return pulse |
| req_grant | output | 1 | One-cycle pulse when a request is accepted |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte address of the read |
| mem_ack | input | 1 | Read handshake; data valid this cycle |
| mem_data | input | 8 | Read data byte |
| hnd_valid | output | 1 | One-cycle handler pointer valid |
| hnd_seg | output | 16 | Handler segment |
| hnd_off | output | 16 | Handler offset |
| hnd_phys | output | 20 | Resolved physical handler address |
| cur_prio | output | 4 | Rank of the running task |
| ovf_err | output | 1 | Push attempted into a full stack |
| unf_err | output | 1 | Pop attempted from an empty stack |

## Verification
The assertions check on every cycle that reads stay inside the table and hold steady until acknowledged, that a grant always raises the current rank, that the stack is never pushed while full or popped while empty, that an overflow is never reported in the same cycle as a grant, and that the valid pulse lasts one cycle. Only the bench scenarios can show the rest. The scenarios cover the byte order and address of every one of the 256 table entries, the arithmetic of the physical address, and the full nesting sequence that restores each rank in reverse order. They also show that a held request is picked up once a return lowers the rank, and that a return during a stalled fetch is ignored.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int SEG_W  = 16;
  localparam int PHYS_W = SEG_W + 4;
  localparam logic [PHYS_W-1:0] TABLE_END = PHYS_W'(1024);
  typedef logic [7:0]       byte_t;
  typedef logic [SEG_W-1:0] word_t;
endpackage

// File: rtl/irqv_prio_stack.sv
module irqv_prio_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop)  cnt <= cnt - CW'(1);
  end

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) mem[AW'(cnt)] <= din;
  end

  assign top   = mem[AW'(cnt - CW'(1))];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R8
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R9
endmodule

// File: rtl/irqv_entry_fetch.sv
module irqv_entry_fetch
  import irqv_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VEC_W-1:0]  vec,
  input  logic              mem_ack,
  input  byte_t             mem_data,
  output logic              busy,
  output logic              mem_rd,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              hnd_valid,
  output word_t             hnd_seg,
  output word_t             hnd_off,
  output logic [PHYS_W-1:0] hnd_phys
);
  logic [VEC_W-1:0] vec_r;
  logic [1:0]       idx;
  byte_t            b0, b1, b2;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= 2'd0;
      vec_r     <= '0;
      hnd_valid <= 1'b0;
      hnd_seg   <= '0;
      hnd_off   <= '0;
      hnd_phys  <= '0;
      b0        <= '0;
      b1        <= '0;
      b2        <= '0;
    end else begin
      hnd_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx   <= 2'd0;
          vec_r <= vec;
        end
      end else if (mem_ack) begin
        idx <= idx + 2'd1;
        case (idx)
          2'd0: b0 <= mem_data;
          2'd1: b1 <= mem_data;
          2'd2: b2 <= mem_data;
          default: begin
            hnd_off   <= {b1, b0};
            hnd_seg   <= {mem_data, b2};
            hnd_phys  <= {mem_data, b2, 4'h0} + {4'h0, b1, b0};
            hnd_valid <= 1'b1;
            busy      <= 1'b0;
          end
        endcase
      end
    end
  end

  assign mem_rd   = busy;
  assign mem_addr = PHYS_W'({vec_r, idx});

  AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr < TABLE_END));  // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));  // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    hnd_valid |=> !hnd_valid);  // R10
endmodule

// File: rtl/irq_vector_fetcher.sv
module irq_vector_fetcher
  import irqv_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              req_hw,
  input  logic              ret,
  output logic              req_grant,
  output logic              mem_rd,
  output logic [PHYS_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_data,
  output logic              hnd_valid,
  output logic [SEG_W-1:0]  hnd_seg,
  output logic [SEG_W-1:0]  hnd_off,
  output logic [PHYS_W-1:0] hnd_phys,
  output logic [PRIO_W:0]   cur_prio,
  output logic              ovf_err,
  output logic              unf_err
);
  localparam int RW = PRIO_W + 1;

  logic [RW-1:0] req_rank, stk_top;
  logic busy, stk_full, stk_empty;
  logic outranks, do_acc, do_ovf, do_ret, do_pop, do_unf;

  assign req_rank = {req_hw, req_prio};                       // hardware bit on top
  assign do_ret   = ret && !busy;                              // ignored mid-fetch
  assign outranks = req_valid && !busy && !ret && (req_rank > cur_prio);
  assign do_acc   = outranks && !stk_full;
  assign do_ovf   = outranks && stk_full;
  assign do_pop   = do_ret && !stk_empty;
  assign do_unf   = do_ret && stk_empty;

  irqv_prio_stack #(.DEPTH(STACK_DEPTH), .W(RW)) u_stack (
    .clk(clk), .rst(rst), .push(do_acc), .pop(do_pop), .din(cur_prio),
    .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  irqv_entry_fetch #(.VEC_W(VEC_W)) u_fetch (
    .clk(clk), .rst(rst), .start(do_acc), .vec(req_vector),
    .mem_ack(mem_ack), .mem_data(mem_data), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .hnd_valid(hnd_valid),
    .hnd_seg(hnd_seg), .hnd_off(hnd_off), .hnd_phys(hnd_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_prio  <= '0;
      req_grant <= 1'b0;
      ovf_err   <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      req_grant <= do_acc;
      ovf_err   <= do_ovf;
      unf_err   <= do_unf;
      if (do_acc)      cur_prio <= req_rank;
      else if (do_pop) cur_prio <= stk_top;
    end
  end

  AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (rst)
    req_grant |-> (cur_prio > $past(cur_prio)));  // R4
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_err && req_grant));  // R8
  AST_UNF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    unf_err |-> $stable(cur_prio));  // R9
endmodule

// File: tb/sim_irq_vector_fetcher.sv
module sim_irq_vector_fetcher;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_hw = 0, ret = 0, mem_ack = 0;
  logic [7:0] req_vector = 0, mem_data = 0;
  logic [2:0] req_prio = 0;
  logic req_grant, mem_rd, hnd_valid, ovf_err, unf_err;
  logic [19:0] mem_addr, hnd_phys;
  logic [15:0] hnd_seg, hnd_off;
  logic [3:0] cur_prio;

  int nvec = 0, nbad = 0, cyc = 0;
  bit hold = 0, done = 0;
  logic [19:0] alog [4];
  int alogn = 0;

  always #5 clk = ~clk;

  irq_vector_fetcher u0 (.*);

  function automatic logic [7:0] bf(input logic [19:0] a);
    logic [19:0] t;
    t = a * 20'd29;
    return t[7:0] ^ a[10:3] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // byte-wide memory responder
  always @(negedge clk) begin
    cyc++;
    mem_ack  <= mem_rd && !hold;
    mem_data <= bf(mem_addr);
    if (mem_rd && !hold) begin
      if (alogn < 4) alog[alogn] = mem_addr;
      alogn++;
    end
  end

  task automatic start_req(input logic [7:0] v, input logic [2:0] p, input logic h);
    bit got = 0;
    req_vector = v; req_prio = p; req_hw = h; req_valid = 1; alogn = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      got = req_grant;
    end
    req_valid = 0;
    chk(got, "R6 grant", 32'(got), 1);
    chk(cur_prio == {h, p}, "R6 cur_prio", 32'(cur_prio), 32'({h, p}));
  endtask

  task automatic finish_req(input logic [7:0] v);
    bit got = 0;
    logic [15:0] es, eo;
    logic [19:0] base;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      got = hnd_valid;
    end
    chk(got, "R10 valid", 32'(got), 1);
    base = {10'd0, v, 2'b00};
    eo = {bf(base + 1), bf(base)};
    es = {bf(base + 3), bf(base + 2)};
    chk(hnd_off == eo, "R1 offset", 32'(hnd_off), 32'(eo));
    chk(hnd_seg == es, "R1 segment", 32'(hnd_seg), 32'(es));
    chk(hnd_phys == 20'({es, 4'h0} + {4'h0, eo}), "R10 phys", 32'(hnd_phys), 32'({es, 4'h0} + {4'h0, eo}));
    for (int k = 0; k < 4; k++)
      chk(alog[k] == base + 20'(k), "R1 order", 32'(alog[k]), 32'(base + 20'(k)));
    chk(alogn == 4, "R2 one byte per ack", 32'(alogn), 4);
    @(negedge clk);
    chk(!hnd_valid, "R10 pulse", 32'(hnd_valid), 0);
  endtask

  task automatic do_ret(input logic [3:0] exp);
    ret = 1; @(negedge clk); ret = 0;
    chk(cur_prio == exp, "R7 restore", 32'(cur_prio), 32'(exp));
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cur_prio == 0, "R6 reset prio", 32'(cur_prio), 0);
    chk(!mem_rd && !hnd_valid && !req_grant, "R6 reset outputs", 32'({mem_rd, hnd_valid, req_grant}), 0);

    // sweep the whole vector table
    for (int v = 0; v < 256; v++) begin
      start_req(8'(v), 3'(v % 8), 1'b1);
      finish_req(8'(v));
      do_ret(4'd0);
    end

    // R4: equal or lower rank is held off
    start_req(8'h11, 3'd0, 1'b1); finish_req(8'h11);
    req_vector = 8'h22; req_prio = 3'd7; req_hw = 0; req_valid = 1;
    repeat (4) begin
      @(negedge clk);
      chk(!req_grant && !mem_rd, "R4 lower rank rejected", 32'({req_grant, mem_rd}), 0);
    end
    req_prio = 3'd0; req_hw = 1;
    repeat (4) begin
      @(negedge clk);
      chk(!req_grant && !mem_rd, "R4 equal rank rejected", 32'({req_grant, mem_rd}), 0);
    end
    // R5: the held request wins after the return lowers the rank
    ret = 1; @(negedge clk); ret = 0;
    chk(cur_prio == 0, "R5 popped", 32'(cur_prio), 0);
    begin
      bit got = 0;
      alogn = 0;
      for (int i = 0; i < 5 && !got; i++) begin @(negedge clk); got = req_grant; end
      req_valid = 0;
      chk(got, "R5 pending granted", 32'(got), 1);
    end
    finish_req(8'h22);
    do_ret(4'd0);

    // R3: hardware level 0 beats software level 7
    start_req(8'h40, 3'd7, 1'b0); finish_req(8'h40);
    start_req(8'h41, 3'd0, 1'b1); finish_req(8'h41);
    chk(cur_prio == 4'd8, "R3 hw over sw", 32'(cur_prio), 8);
    do_ret(4'd7); do_ret(4'd0);

    // R8 / R7 / R9: nesting to full depth
    for (int r = 1; r <= 8; r++) begin
      start_req(8'(r), 3'(r % 8), 1'(r / 8));
      finish_req(8'(r));
    end
    req_vector = 8'h77; req_prio = 3'd1; req_hw = 1; req_valid = 1;
    @(negedge clk);
    chk(ovf_err && !req_grant, "R8 overflow flagged", 32'({ovf_err, req_grant}), 2);
    @(negedge clk);
    req_valid = 0;
    chk(cur_prio == 4'd8 && !mem_rd, "R8 rank kept", 32'(cur_prio), 8);
    for (int r = 7; r >= 0; r--) do_ret(4'(r));
    ret = 1; @(negedge clk); ret = 0;
    chk(unf_err, "R9 underflow flagged", 32'(unf_err), 1);
    chk(cur_prio == 0, "R9 rank kept", 32'(cur_prio), 0);
    @(negedge clk);
    chk(!unf_err, "R9 one cycle", 32'(unf_err), 0);

    // R2 / R11: stalled memory, return during the fetch
    hold = 1;
    start_req(8'h33, 3'd2, 1'b1);
    repeat (4) begin
      @(negedge clk);
      chk(mem_rd && mem_addr == 20'hCC, "R2 held read", 32'(mem_addr), 32'hCC);
    end
    ret = 1; @(negedge clk); ret = 0;
    chk(cur_prio == 4'd10 && !unf_err, "R11 ret ignored", 32'(cur_prio), 10);
    hold = 0;
    finish_req(8'h33);
    chk(cur_prio == 4'd10, "R11 rank after fetch", 32'(cur_prio), 10);
    do_ret(4'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule